// File: doc/BRIEF.md
# Local Current Consolidation and Restraint

This block sits at one terminal of a line current differential scheme where the terminal is fed by several current inputs, such as the two breakers of a breaker-and-a-half bay. Each phase has up to four local phasors. The block turns them into one small record that can be sent to the far terminals. For each phase the record holds three values: the real part of the local sub-sum, the imaginary part of that sub-sum, and one restraint value. The raw local currents are never sent.

The restraint is not built from a sum. It is built from the largest squared magnitude among the enabled local inputs. That value is shaped locally by a dual-slope characteristic, then scaled by a factor that depends on whether the line has two or three terminals. A dynamic error term, weighted by an adaptive multiplier, is added on top. All restraint quantities stay in the squared domain, so no square root is needed. Every input can be disabled on its own. With a single enabled input the block behaves like a single-breaker terminal.

A new input set is taken on the cycle `in_valid` is high. The record appears, with a one-cycle `out_valid` pulse, a fixed two cycles later.

Top module: `lcc_consolidate`

## Requirements
- R1: For each phase, `out_re` is the signed sum of the real parts of the enabled inputs of that phase, and `out_im` is the same sum for the imaginary parts. Both are 16-bit two's complement. The input layout is phase-major: input i of phase p occupies slot p*4+i.
- R2: For each phase, the restraint measure R2 is the largest squared magnitude among the enabled inputs of that phase. If no input is enabled, R2 is zero.
- R3: An input whose `in_en` bit is 0 has no effect on the sums or on the maximum, whatever its values are.
- R4: The slope inputs are squared slopes, unsigned with 8 fractional bits. If R2 < B2, the core value is S1sq*R2. Otherwise, when R2 >= B2, the core value is S2sq*(R2-B2) + S1sq*B2.
- R5: When `cfg_three_term` is 0 (two terminals), the scaled value is core*2. When it is 1 (three terminals), the scaled value is floor(core*4/3). The shaped restraint is the scaled value shifted right by 8.
- R6: `out_rest_sq` is the shaped restraint plus ((mult*dyn) >> 8). The multiplier is unsigned with 8 fractional bits.
- R7: A sum outside [-32768, 32767] clamps to the nearest limit, keeping its sign. A restraint above 2^28-1 clamps to 2^28-1.
- R8: `out_valid` pulses for exactly one cycle, two clock edges after the edge that samples `in_valid`. Between updates, all outputs hold their last values, whatever the inputs do.
- R9: While `rst` is high and after it, until the first update, `out_valid` is 0 and every output value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Take the input set on this edge |
| in_en | input | 4 | Per-input enable, shared by all phases |
| in_re | input | 192 | Real parts, 16-bit signed, slot p*4+i |
| in_im | input | 192 | Imaginary parts, 16-bit signed, slot p*4+i |
| in_mag_sq | input | 288 | Squared magnitudes, 24-bit unsigned, slot p*4+i |
| cfg_s1_sq | input | 12 | First slope squared, 8 fractional bits |
| cfg_s2_sq | input | 12 | Second slope squared, 8 fractional bits |
| cfg_brk_sq | input | 24 | Breakpoint squared |
| cfg_three_term | input | 1 | 0 = two terminals, 1 = three terminals |
| in_dyn_sq | input | 72 | Dynamic error term squared, 24 bits per phase |
| in_mult | input | 36 | Restraint multiplier, 12 bits per phase, 8 fractional bits |
| out_valid | output | 1 | Record update strobe |
| out_re | output | 48 | Real sub-sum, 16 bits per phase |
| out_im | output | 48 | Imaginary sub-sum, 16 bits per phase |
| out_rest_sq | output | 84 | Total restraint squared, 28 bits per phase |

## Verification
The directed patterns are chosen to separate the two branches of the characteristic. Restraints below the breakpoint and above it show whether the right slope is applied. Both terminal modes are used, which exposes a wrong scaling factor. A disabled input is given the largest values of its phase, so any leak into the sum or the maximum shows up in the output. Overflowing sums and restraints are used to tell saturation apart from wraparound. Changing the inputs with no strobe shows that the record holds. A seeded pseudo-random sweep then mixes enables, modes and magnitudes.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
    localparam int unsigned LCC_PHASES = 3;

    typedef enum logic {
        TERM_TWO   = 1'b0,
        TERM_THREE = 1'b1
    } term_mode_e;
endpackage

// File: rtl/lcc_phasor_sum.sv
module lcc_phasor_sum #(
    parameter int unsigned NUM_IN = 4,
    parameter int unsigned PH_W   = 16,
    parameter int unsigned ACC_W  = 19
) (
    input  logic [NUM_IN*PH_W-1:0] in_vec,
    input  logic [NUM_IN-1:0]      en,
    output logic signed [ACC_W-1:0] sum
);
    always_comb begin
        logic signed [ACC_W-1:0] acc_d;
        acc_d = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (en[i]) begin
                acc_d = acc_d + {{(ACC_W-PH_W){in_vec[i*PH_W+PH_W-1]}},
                                 in_vec[i*PH_W +: PH_W]};
            end
        end
        sum = acc_d;
    end
endmodule

// File: rtl/lcc_max_pick.sv
module lcc_max_pick #(
    parameter int unsigned NUM_IN = 4,
    parameter int unsigned MAG_W  = 24
) (
    input  logic [NUM_IN*MAG_W-1:0] mag_vec,
    input  logic [NUM_IN-1:0]       en,
    output logic [MAG_W-1:0]        max_mag
);
    always_comb begin
        logic [MAG_W-1:0] best_d;
        best_d = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (en[i] && (mag_vec[i*MAG_W +: MAG_W] > best_d)) begin
                best_d = mag_vec[i*MAG_W +: MAG_W];
            end
        end
        max_mag = best_d;
    end
endmodule

// File: rtl/lcc_restraint_shape.sv
module lcc_restraint_shape
    import lcc_pkg::*;
#(
    parameter int unsigned MAG_W     = 24,
    parameter int unsigned SLOPE_W   = 12,
    parameter int unsigned MULT_W    = 12,
    parameter int unsigned FRAC_BITS = 8,
    parameter int unsigned RST_W     = 28
) (
    input  logic [MAG_W-1:0]   rest_sq,
    input  logic [MAG_W-1:0]   brk_sq,
    input  logic [SLOPE_W-1:0] s1_sq,
    input  logic [SLOPE_W-1:0] s2_sq,
    input  term_mode_e         mode,
    input  logic [MAG_W-1:0]   dyn_sq,
    input  logic [MULT_W-1:0]  mult,
    output logic [RST_W-1:0]   total_sq
);
    localparam int unsigned CORE_W = SLOPE_W + MAG_W + 1;
    localparam int unsigned SCL_W  = CORE_W + 2;
    localparam int unsigned DYN_W  = MULT_W + MAG_W;
    localparam int unsigned SHP_W  = SCL_W - FRAC_BITS;
    localparam int unsigned DYP_W  = DYN_W - FRAC_BITS;
    localparam int unsigned TOT_W  = ((SHP_W > DYP_W) ? SHP_W : DYP_W) + 1;
    localparam logic [TOT_W-1:0] TOT_MAX = TOT_W'({RST_W{1'b1}});

    logic              below_knee;
    logic [CORE_W-1:0] core;
    logic [SCL_W-1:0]  scaled;
    logic [SCL_W-1:0]  shaped;
    logic [DYN_W-1:0]  dyn_part;
    logic [TOT_W-1:0]  total_wide;

    always_comb begin
        below_knee = (rest_sq < brk_sq);
        if (below_knee) begin
            core = CORE_W'(s1_sq) * CORE_W'(rest_sq);
        end else begin
            core = CORE_W'(s2_sq) * CORE_W'(rest_sq - brk_sq)
                 + CORE_W'(s1_sq) * CORE_W'(brk_sq);
        end

        if (mode == TERM_THREE) begin
            scaled = (SCL_W'(core) << 2) / SCL_W'(3);
        end else begin
            scaled = SCL_W'(core) << 1;
        end
        shaped = scaled >> FRAC_BITS;

        dyn_part   = (DYN_W'(mult) * DYN_W'(dyn_sq)) >> FRAC_BITS;
        total_wide = TOT_W'(shaped) + TOT_W'(dyn_part);

        if (total_wide > TOT_MAX) begin
            total_sq = {RST_W{1'b1}};
        end else begin
            total_sq = total_wide[RST_W-1:0];
        end
    end
endmodule

// File: rtl/lcc_consolidate.sv
module lcc_consolidate
    import lcc_pkg::*;
#(
    parameter int unsigned NUM_IN    = 4,
    parameter int unsigned PH_W      = 16,
    parameter int unsigned MAG_W     = 24,
    parameter int unsigned SLOPE_W   = 12,
    parameter int unsigned MULT_W    = 12,
    parameter int unsigned FRAC_BITS = 8,
    parameter int unsigned SUM_W     = 16,
    parameter int unsigned RST_W     = 28
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                in_valid,
    input  logic [NUM_IN-1:0]                   in_en,
    input  logic [LCC_PHASES*NUM_IN*PH_W-1:0]   in_re,
    input  logic [LCC_PHASES*NUM_IN*PH_W-1:0]   in_im,
    input  logic [LCC_PHASES*NUM_IN*MAG_W-1:0]  in_mag_sq,
    input  logic [SLOPE_W-1:0]                  cfg_s1_sq,
    input  logic [SLOPE_W-1:0]                  cfg_s2_sq,
    input  logic [MAG_W-1:0]                    cfg_brk_sq,
    input  logic                                cfg_three_term,
    input  logic [LCC_PHASES*MAG_W-1:0]         in_dyn_sq,
    input  logic [LCC_PHASES*MULT_W-1:0]        in_mult,
    output logic                                out_valid,
    output logic [LCC_PHASES*SUM_W-1:0]         out_re,
    output logic [LCC_PHASES*SUM_W-1:0]         out_im,
    output logic [LCC_PHASES*RST_W-1:0]         out_rest_sq
);
    localparam int unsigned NPH   = LCC_PHASES;
    localparam int unsigned ACC_W = PH_W + $clog2(NUM_IN + 1);
    localparam logic signed [ACC_W-1:0] SUM_HI = ACC_W'((2 ** (SUM_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SUM_LO = -SUM_HI - ACC_W'(1);

    typedef struct packed {
        logic                              s1_vld;
        logic [NUM_IN-1:0]                 en;
        logic [NPH-1:0][ACC_W-1:0]         re_acc;
        logic [NPH-1:0][ACC_W-1:0]         im_acc;
        logic [NPH-1:0][MAG_W-1:0]         rmax;
        logic [NPH-1:0][MAG_W-1:0]         dyn;
        logic [NPH-1:0][MULT_W-1:0]        mult;
        logic [SLOPE_W-1:0]                s1;
        logic [SLOPE_W-1:0]                s2;
        logic [MAG_W-1:0]                  brk;
        logic                              three;
        logic                              o_vld;
        logic [NPH-1:0][SUM_W-1:0]         o_re;
        logic [NPH-1:0][SUM_W-1:0]         o_im;
        logic [NPH-1:0][RST_W-1:0]         o_rest;
    } lcc_state_t;

    lcc_state_t state_d, state_q;

    logic signed [ACC_W-1:0] re_sum  [NPH];
    logic signed [ACC_W-1:0] im_sum  [NPH];
    logic [MAG_W-1:0]        max_w   [NPH];
    logic [RST_W-1:0]        rest_w  [NPH];

    function automatic logic [SUM_W-1:0] sat_sum(input logic signed [ACC_W-1:0] v);
        if (v > SUM_HI) begin
            return SUM_HI[SUM_W-1:0];
        end else if (v < SUM_LO) begin
            return SUM_LO[SUM_W-1:0];
        end
        return v[SUM_W-1:0];
    endfunction

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        lcc_phasor_sum #(.NUM_IN(NUM_IN), .PH_W(PH_W), .ACC_W(ACC_W)) u_re_sum (
            .in_vec (in_re[p*NUM_IN*PH_W +: NUM_IN*PH_W]),
            .en     (in_en),
            .sum    (re_sum[p])
        );
        lcc_phasor_sum #(.NUM_IN(NUM_IN), .PH_W(PH_W), .ACC_W(ACC_W)) u_im_sum (
            .in_vec (in_im[p*NUM_IN*PH_W +: NUM_IN*PH_W]),
            .en     (in_en),
            .sum    (im_sum[p])
        );
        lcc_max_pick #(.NUM_IN(NUM_IN), .MAG_W(MAG_W)) u_max (
            .mag_vec (in_mag_sq[p*NUM_IN*MAG_W +: NUM_IN*MAG_W]),
            .en      (in_en),
            .max_mag (max_w[p])
        );
        lcc_restraint_shape #(
            .MAG_W(MAG_W), .SLOPE_W(SLOPE_W), .MULT_W(MULT_W),
            .FRAC_BITS(FRAC_BITS), .RST_W(RST_W)
        ) u_shape (
            .rest_sq  (state_q.rmax[p]),
            .brk_sq   (state_q.brk),
            .s1_sq    (state_q.s1),
            .s2_sq    (state_q.s2),
            .mode     (term_mode_e'(state_q.three)),
            .dyn_sq   (state_q.dyn[p]),
            .mult     (state_q.mult[p]),
            .total_sq (rest_w[p])
        );

        // R7: saturation never flips the sign of a non-negative sum
        a_r7_sign_kept: assert property (@(posedge clk) disable iff (rst)
            (state_q.s1_vld && !state_q.re_acc[p][ACC_W-1]) |=> !out_re[p*SUM_W+SUM_W-1]);

        // R2/R6: nothing to restrain and no dynamic term gives zero restraint
        a_r2_zero_rest: assert property (@(posedge clk) disable iff (rst)
            (state_q.s1_vld && state_q.rmax[p] == '0 && state_q.dyn[p] == '0)
            |=> (out_rest_sq[p*RST_W +: RST_W] == '0));
    end

    always_comb begin
        state_d        = state_q;
        state_d.s1_vld = in_valid;
        if (in_valid) begin
            state_d.en    = in_en;
            state_d.s1    = cfg_s1_sq;
            state_d.s2    = cfg_s2_sq;
            state_d.brk   = cfg_brk_sq;
            state_d.three = cfg_three_term;
            state_d.dyn   = in_dyn_sq;
            state_d.mult  = in_mult;
            for (int p = 0; p < NPH; p++) begin
                state_d.re_acc[p] = re_sum[p];
                state_d.im_acc[p] = im_sum[p];
                state_d.rmax[p]   = max_w[p];
            end
        end

        state_d.o_vld = state_q.s1_vld;
        if (state_q.s1_vld) begin
            for (int p = 0; p < NPH; p++) begin
                state_d.o_re[p]   = sat_sum($signed(state_q.re_acc[p]));
                state_d.o_im[p]   = sat_sum($signed(state_q.im_acc[p]));
                state_d.o_rest[p] = rest_w[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid   = state_q.o_vld;
    assign out_re      = state_q.o_re;
    assign out_im      = state_q.o_im;
    assign out_rest_sq = state_q.o_rest;

    // R3: with every input disabled the record carries zero sums
    a_r3_disabled_zero: assert property (@(posedge clk) disable iff (rst)
        (state_q.s1_vld && state_q.en == '0) |=> (out_re == '0 && out_im == '0));

    // R8: an update strobe is always caused by a sample two edges earlier
    a_r8_valid_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid, 2));

    // R8: no pending update means the record holds
    a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
        !state_q.s1_vld |=> ($stable(out_re) && $stable(out_im) && $stable(out_rest_sq)));
endmodule

// File: tb/lcc_consolidate_tb.sv
module lcc_consolidate_tb_top;
    localparam int NPH = 3;
    localparam int NIN = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [NIN-1:0] in_en = '0;
    logic [NPH*NIN*16-1:0] in_re = '0;
    logic [NPH*NIN*16-1:0] in_im = '0;
    logic [NPH*NIN*24-1:0] in_mag_sq = '0;
    logic [11:0] cfg_s1_sq = '0;
    logic [11:0] cfg_s2_sq = '0;
    logic [23:0] cfg_brk_sq = '0;
    logic cfg_three_term = 1'b0;
    logic [NPH*24-1:0] in_dyn_sq = '0;
    logic [NPH*12-1:0] in_mult = '0;
    logic out_valid;
    logic [NPH*16-1:0] out_re;
    logic [NPH*16-1:0] out_im;
    logic [NPH*28-1:0] out_rest_sq;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    longint v_re [NPH][NIN];
    longint v_im [NPH][NIN];
    longint v_mag[NPH][NIN];
    longint v_dyn[NPH];
    longint v_mult[NPH];
    longint v_s1, v_s2, v_brk;
    int     v_mode;
    logic [NIN-1:0] v_en;

    always #4 clk = ~clk;

    lcc_consolidate dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_en(in_en),
        .in_re(in_re), .in_im(in_im), .in_mag_sq(in_mag_sq),
        .cfg_s1_sq(cfg_s1_sq), .cfg_s2_sq(cfg_s2_sq), .cfg_brk_sq(cfg_brk_sq),
        .cfg_three_term(cfg_three_term), .in_dyn_sq(in_dyn_sq), .in_mult(in_mult),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
        .out_rest_sq(out_rest_sq)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint clamp_sum(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint exp_re(int p, bit imag);
        longint s = 0;
        for (int i = 0; i < NIN; i++)
            if (v_en[i]) s += imag ? v_im[p][i] : v_re[p][i];
        return clamp_sum(s);
    endfunction

    function automatic longint exp_rest(int p);
        longint r2 = 0;
        longint core;
        longint sc;
        longint tot;
        for (int i = 0; i < NIN; i++)
            if (v_en[i] && v_mag[p][i] > r2) r2 = v_mag[p][i];
        if (r2 < v_brk) core = v_s1 * r2;
        else            core = v_s2 * (r2 - v_brk) + v_s1 * v_brk;
        sc  = (v_mode != 0) ? (core * 4) / 3 : core * 2;
        tot = (sc >>> 8) + ((v_mult[p] * v_dyn[p]) >>> 8);
        if (tot > 268435455) tot = 268435455;
        return tot;
    endfunction

    function automatic longint got_re(int p);
        return longint'($signed(out_re[p*16 +: 16]));
    endfunction
    function automatic longint got_im(int p);
        return longint'($signed(out_im[p*16 +: 16]));
    endfunction
    function automatic longint got_rest(int p);
        return longint'(out_rest_sq[p*28 +: 28]);
    endfunction

    task automatic pack_inputs();
        for (int p = 0; p < NPH; p++) begin
            for (int i = 0; i < NIN; i++) begin
                in_re[(p*NIN+i)*16 +: 16]     = v_re[p][i][15:0];
                in_im[(p*NIN+i)*16 +: 16]     = v_im[p][i][15:0];
                in_mag_sq[(p*NIN+i)*24 +: 24] = v_mag[p][i][23:0];
            end
            in_dyn_sq[p*24 +: 24] = v_dyn[p][23:0];
            in_mult[p*12 +: 12]   = v_mult[p][11:0];
        end
        in_en          = v_en;
        cfg_s1_sq      = v_s1[11:0];
        cfg_s2_sq      = v_s2[11:0];
        cfg_brk_sq     = v_brk[23:0];
        cfg_three_term = v_mode[0];
    endtask

    task automatic clear_vals();
        for (int p = 0; p < NPH; p++) begin
            for (int i = 0; i < NIN; i++) begin
                v_re[p][i] = 0; v_im[p][i] = 0; v_mag[p][i] = 0;
            end
            v_dyn[p] = 0; v_mult[p] = 256;
        end
        v_s1 = 23; v_s2 = 125; v_brk = 4000; v_mode = 0; v_en = 4'hF;
    endtask

    // one update, with strobe timing checks and checks on all nine values
    task automatic run_update(string r_sum, string r_rest);
        @(negedge clk);
        pack_inputs();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8", "valid early", longint'(out_valid), 0);
        @(negedge clk);
        chk("R8", "valid pulse", longint'(out_valid), 1);
        for (int p = 0; p < NPH; p++) begin
            chk(r_sum,  $sformatf("re ph%0d", p),   got_re(p),   exp_re(p, 1'b0));
            chk(r_sum,  $sformatf("im ph%0d", p),   got_im(p),   exp_re(p, 1'b1));
            chk(r_rest, $sformatf("rest ph%0d", p), got_rest(p), exp_rest(p));
        end
        @(negedge clk);
        chk("R8", "valid single", longint'(out_valid), 0);
    endtask

    task automatic t_reset();
        chk("R9", "valid after reset", longint'(out_valid), 0);
        chk("R9", "re after reset", longint'(out_re), 0);
        chk("R9", "im after reset", longint'(out_im), 0);
        chk("R9", "rest after reset", longint'(out_rest_sq), 0);
    endtask

    task automatic t_basic_below_knee();
        clear_vals();
        for (int p = 0; p < NPH; p++)
            for (int i = 0; i < NIN; i++) begin
                v_re[p][i]  = 100 * (i + 1) - 50 * p;
                v_im[p][i]  = -70 * i + 13 * p;
                v_mag[p][i] = 500 + 300 * i + 7 * p;
            end
        run_update("R1", "R2 R4 R5");
    endtask

    task automatic t_above_knee_three();
        clear_vals();
        v_mode = 1;
        for (int p = 0; p < NPH; p++)
            for (int i = 0; i < NIN; i++) begin
                v_re[p][i]  = 1000 - 400 * i;
                v_im[p][i]  = 250 * i + p;
                v_mag[p][i] = 20000 * (4 - i) + 1111 * p;
            end
        run_update("R1", "R4 R5");
        v_mode = 0;
        run_update("R1", "R5");
    endtask

    task automatic t_disabled();
        clear_vals();
        v_en = 4'b0101;
        for (int p = 0; p < NPH; p++) begin
            v_re[p][0] = 300; v_re[p][2] = -120; v_im[p][0] = 40; v_im[p][2] = 60;
            v_mag[p][0] = 900; v_mag[p][2] = 2500 + p;
            v_re[p][1] = 32000; v_re[p][3] = -32000; v_im[p][1] = 31000; v_im[p][3] = 29000;
            v_mag[p][1] = 16000000; v_mag[p][3] = 15000000;
        end
        run_update("R3", "R3");
        v_en = 4'b0000;
        run_update("R3", "R2 R3");
    endtask

    task automatic t_single();
        clear_vals();
        v_en = 4'b0010;
        for (int p = 0; p < NPH; p++) begin
            v_re[p][1] = -1234 + p; v_im[p][1] = 4321; v_mag[p][1] = 3999 + p;
            v_re[p][0] = 5; v_mag[p][0] = 9000000;
        end
        run_update("R1", "R2 R4");
    endtask

    task automatic t_dynamic();
        clear_vals();
        for (int p = 0; p < NPH; p++) begin
            v_mag[p][p] = 6000;
            v_dyn[p]    = 100000 * (p + 1);
            v_mult[p]   = 256 + 512 * p;
        end
        run_update("R1", "R6");
    endtask

    task automatic t_saturate();
        clear_vals();
        v_s2 = 4095; v_brk = 10;
        for (int p = 0; p < NPH; p++)
            for (int i = 0; i < NIN; i++) begin
                v_re[p][i]  = (p == 1) ? -30000 : 30000;
                v_im[p][i]  = (p == 2) ? 32767 : -32768;
                v_mag[p][i] = 16777215;
            end
        v_dyn[0] = 16777215; v_mult[0] = 4095;
        run_update("R7", "R7");
    endtask

    task automatic t_hold();
        longint keep_re[NPH];
        longint keep_im[NPH];
        longint keep_rest[NPH];
        clear_vals();
        for (int p = 0; p < NPH; p++) begin
            v_re[p][3] = 777; v_im[p][0] = -555; v_mag[p][2] = 12345;
        end
        run_update("R1", "R4");
        for (int p = 0; p < NPH; p++) begin
            keep_re[p] = exp_re(p, 1'b0); keep_im[p] = exp_re(p, 1'b1);
            keep_rest[p] = exp_rest(p);
            v_re[p][0] = 9999; v_im[p][1] = 8888; v_mag[p][0] = 7000000;
        end
        v_mode = 1;
        pack_inputs();
        repeat (5) @(negedge clk);
        chk("R8", "no strobe", longint'(out_valid), 0);
        for (int p = 0; p < NPH; p++) begin
            chk("R8", $sformatf("hold re ph%0d", p), got_re(p), keep_re[p]);
            chk("R8", $sformatf("hold im ph%0d", p), got_im(p), keep_im[p]);
            chk("R8", $sformatf("hold rest ph%0d", p), got_rest(p), keep_rest[p]);
        end
    endtask

    task automatic t_sweep();
        for (int n = 0; n < 24; n++) begin
            clear_vals();
            v_en   = 4'($urandom_range(0, 15));
            v_mode = int'($urandom_range(0, 1));
            v_s1   = longint'($urandom_range(0, 4095));
            v_s2   = longint'($urandom_range(0, 4095));
            v_brk  = longint'($urandom_range(0, 16777215));
            for (int p = 0; p < NPH; p++) begin
                for (int i = 0; i < NIN; i++) begin
                    v_re[p][i]  = longint'($urandom_range(0, 65535)) - 32768;
                    v_im[p][i]  = longint'($urandom_range(0, 65535)) - 32768;
                    v_mag[p][i] = longint'($urandom_range(0, 16777215)) >> (n % 12);
                end
                v_dyn[p]  = longint'($urandom_range(0, 16777215)) >> (n % 8);
                v_mult[p] = longint'($urandom_range(0, 4095));
            end
            run_update("R1 R7", "R4 R5 R6");
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic_below_knee();
        t_above_knee_three();
        t_disabled();
        t_single();
        t_dynamic();
        t_saturate();
        t_hold();
        t_sweep();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule